// File: doc/BRIEF.md
# UART Register Bank with Interrupt Identification

This block is the byte-wide, register-mapped control front end of a 16550-style serial port. A host drives a 3-bit offset, a data byte and separate read and write strobes. The block holds the interrupt enable, line control, modem control, scratch and divisor registers. It takes status from the serial datapath (receive byte and ready flag, character timeout, line error pulses, transmit empty flags and modem input levels) and turns it into readable status and a prioritised interrupt identification code. It drives the divisor, the line format fields, the modem outputs, the FIFO control strobes and a single interrupt line back to that datapath.

Bit 7 of the line control register redirects offsets 0 and 1 to the two divisor bytes. With that bit clear, offset 0 is the data port: a write produces a one-cycle transmit strobe carrying the byte, and a read returns the receive byte and produces a one-cycle receive strobe. Some reads have side effects. Reading line status, modem status or the identification register acknowledges the interrupt source that belongs to it. Read data is combinational from the offset, and all side effects take place at the clock edge that ends the read cycle.

Top module: `uart_regbank`

## Requirements
- R1: After reset, offset 2 reads 0x01 and offsets 1, 3, 4, 6 and 7 read 0x00. The divisor output is 0 and irq is low.
- R2: When line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. The divisor output is {high, low}, and no transmit or receive strobe occurs. When bit 7 is clear, a write to offset 0 pulses tx_wr for that cycle with tx_data equal to the written byte. A read of offset 0 returns rx_byte and pulses rx_rd. Offset 1 holds the interrupt enable in bits 3:0, and bits 7:4 read as 0.
- R3: Line control fields drive the outputs as follows: word_len = bits 1:0, stop_bits = bit 2, par_en = bit 3, par_even = bit 4, par_stick = bit 5, brk = bit 6.
- R4: Modem control bit 0 drives dtr, bit 1 rts, bit 2 out1 and bit 3 out2. irq is high exactly when out2 is set and some enabled source is pending.
- R5: Offset 2 bits 3:0 give the highest-priority enabled source. The order, highest first, is: line status 0x6 (enable bit 2), received data 0x4 (rx_ready, enable bit 0), timeout 0xC (rx_timeout, enable bit 0), transmit empty 0x2 (enable bit 1), modem status 0x0 (enable bit 3). When no enabled source is pending, bits 3:0 read 0x1.
- R6: Offset 5 reads {0, tx_idle, thr_empty, break, framing, parity, overrun, rx_ready} from bit 7 down to bit 0. The error bits latch pulses on line_err[3:0], where bit 0 is overrun, bit 1 parity, bit 2 framing and bit 3 break. A read of offset 5 clears the error bits, which ends the line status interrupt.
- R7: The transmit empty source arms when thr_empty rises, and when enable bit 1 changes from 0 to 1 while thr_empty is high. It is cleared by a read of offset 2 that reports code 0x2, by a transmit write, or by thr_empty falling. A read of offset 2 that reports another code leaves it armed.
- R8: Offset 6 bits 7:4 give modem_in[3:0] (CD, RI, DSR, CTS), sampled one cycle late. Bits 3:0 latch any change on the matching line. A read of offset 6 clears bits 3:0.
- R9: A write to offset 2 stores bit 0 as fifo_en, which makes offset 2 bits 7:6 read 11. It stores bits 7:6 as rx_trig. Bit 1 and bit 2 of that write give one-cycle rx_fifo_clr and tx_fifo_clr pulses.
- R10: Offset 7 is plain read/write storage. Writes to offsets 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the clock edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rx_byte | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Receive data available |
| rx_timeout | input | 1 | Character timeout from the receive path |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| thr_empty | input | 1 | Transmit holding storage empty |
| tx_idle | input | 1 | Transmit shifter empty |
| modem_in | input | 4 | Modem input levels: CD, RI, DSR, CTS (bit 3 down to bit 0) |
| tx_wr | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_rd | output | 1 | Receive byte consumed |
| fifo_en | output | 1 | FIFO mode enable |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| rx_trig | output | 2 | Receive trigger level select |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits select |
| stop_bits | output | 1 | Extra stop bit |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Stick parity |
| brk | output | 1 | Force break |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | Auxiliary output 1 |
| out2 | output | 1 | Auxiliary output 2, interrupt gate |
| irq | output | 1 | Interrupt request |

## Verification
The identification logic is tested with every source active at the same time. Sources are then removed one at a time, by acknowledging reads or by dropping inputs. This shows that each code appears in its priority slot, and that it is not just the only source present. A read of the identification register is made while line status outranks a pending transmit empty. That read separates a clear tied to the reported code from a clear on any identification read. Address patterns are issued with the divisor access bit set and cleared, and a register value is written next to the read-only offsets. These show that the overlay reroutes both reads and writes, and that the strobes to the datapath are suppressed.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

   localparam logic [2:0] OFS_DATA  = 3'd0;
   localparam logic [2:0] OFS_IEN   = 3'd1;
   localparam logic [2:0] OFS_IDENT = 3'd2;
   localparam logic [2:0] OFS_LINE  = 3'd3;
   localparam logic [2:0] OFS_MODEM = 3'd4;
   localparam logic [2:0] OFS_LSTAT = 3'd5;
   localparam logic [2:0] OFS_MSTAT = 3'd6;
   localparam logic [2:0] OFS_SCR   = 3'd7;

   // enable bit positions inside the interrupt enable register
   localparam int IEN_RX    = 0;
   localparam int IEN_TX    = 1;
   localparam int IEN_LINE  = 2;
   localparam int IEN_MODEM = 3;

   typedef enum logic [3:0] {
      ID_MODEM   = 4'h0,
      ID_NONE    = 4'h1,
      ID_TXEMPTY = 4'h2,
      ID_RXDATA  = 4'h4,
      ID_LINE    = 4'h6,
      ID_TIMEOUT = 4'hC
   } irq_id_e;

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode #(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   wr_en,
   input  logic                   rd_en,
   output logic [(1<<ADDR_W)-1:0] wr_hit,
   output logic [(1<<ADDR_W)-1:0] rd_hit
);
   localparam int SLOTS = 1 << ADDR_W;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign wr_hit[s] = wr_en && (addr == ADDR_W'(s));
      assign rd_hit[s] = rd_en && (addr == ADDR_W'(s));
   end
endmodule

// File: rtl/uart_regbank_flags.sv
module uart_regbank_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_in,
   input  logic         clr,
   output logic [N-1:0] flag_q
);
   // sticky flags: a new event wins over a clear in the same cycle
   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[b] <= 1'b0;
         else        flag_q[b] <= set_in[b] | (flag_q[b] & ~clr);
      end
   end
endmodule

// File: rtl/uart_regbank_modem.sv
module uart_regbank_modem #(
   parameter int LINES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines_in,
   input  logic             clr,
   output logic [LINES-1:0] level_q,
   output logic [LINES-1:0] delta_q
);
   logic [LINES-1:0] change;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= lines_in;
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      assign change[l] = level_q[l] ^ lines_in[l];
   end

   uart_regbank_flags #(.N(LINES)) u_delta (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (change),
      .clr    (clr),
      .flag_q (delta_q)
   );
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
   import uart_regbank_pkg::*;
#(
   parameter int IEN_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IEN_W-1:0]  ien,
   input  logic              line_act,
   input  logic              rx_ready,
   input  logic              rx_timeout,
   input  logic              modem_act,
   input  logic              thr_empty,
   input  logic              ien_tx_rise,
   input  logic              tx_wr,
   input  logic              ident_rd,
   input  logic              fifo_on,
   output logic [DATA_W-1:0] ident,
   output logic              pending,
   output logic              thre_pend
);
   irq_id_e code;
   logic    thr_prev_q;
   logic    arm, drop;

   always_comb begin
      code = ID_NONE;
      if      (ien[IEN_LINE]  && line_act)   code = ID_LINE;
      else if (ien[IEN_RX]    && rx_ready)   code = ID_RXDATA;
      else if (ien[IEN_RX]    && rx_timeout) code = ID_TIMEOUT;
      else if (ien[IEN_TX]    && thre_pend)  code = ID_TXEMPTY;
      else if (ien[IEN_MODEM] && modem_act)  code = ID_MODEM;
   end

   assign pending = (code != ID_NONE);
   assign ident   = {fifo_on, fifo_on, {(DATA_W-6){1'b0}}, code};

   assign arm  = (thr_empty & ~thr_prev_q) | (ien_tx_rise & thr_empty);
   assign drop = (ident_rd && code == ID_TXEMPTY) | tx_wr | ~thr_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_prev_q <= 1'b1;
         thre_pend  <= 1'b0;
      end else begin
         thr_prev_q <= thr_empty;
         if (arm)       thre_pend <= 1'b1;
         else if (drop) thre_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_regbank_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ERR_N        = 4,
   parameter int MODEM_N      = 4,
   parameter int IEN_W        = 4,
   parameter bit FIFO_PRESENT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          addr,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [DATA_W-1:0]   rx_byte,
   input  logic                rx_ready,
   input  logic                rx_timeout,
   input  logic [ERR_N-1:0]    line_err,
   input  logic                thr_empty,
   input  logic                tx_idle,
   input  logic [MODEM_N-1:0]  modem_in,
   output logic                tx_wr,
   output logic [DATA_W-1:0]   tx_data,
   output logic                rx_rd,
   output logic                fifo_en,
   output logic                rx_fifo_clr,
   output logic                tx_fifo_clr,
   output logic [1:0]          rx_trig,
   output logic [2*DATA_W-1:0] divisor,
   output logic [1:0]          word_len,
   output logic                stop_bits,
   output logic                par_en,
   output logic                par_even,
   output logic                par_stick,
   output logic                brk,
   output logic                dtr,
   output logic                rts,
   output logic                out1,
   output logic                out2,
   output logic                irq
);
   localparam int ADDR_W = 3;
   localparam int SLOTS  = 1 << ADDR_W;
   localparam int MCR_W  = 4;
   localparam int DLAB   = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("uart_regbank: DATA_W must be 8");
   end
   if (ERR_N + 4 != DATA_W) begin : g_bad_err_n
      $error("uart_regbank: ERR_N must leave room for 4 line status bits");
   end
   if (2 * MODEM_N != DATA_W) begin : g_bad_modem_n
      $error("uart_regbank: MODEM_N must fill half a byte");
   end
   if (IEN_W != 4) begin : g_bad_ien_w
      $error("uart_regbank: IEN_W must be 4");
   end

   logic [SLOTS-1:0]   wr_hit, rd_hit;
   logic [DATA_W-1:0]  lcr_q, scr_q, dll_q, dlm_q;
   logic [IEN_W-1:0]   ier_q;
   logic [MCR_W-1:0]   mcr_q;
   logic [ERR_N-1:0]   err_q;
   logic [MODEM_N-1:0] msr_lvl, msr_dlt;
   logic [DATA_W-1:0]  ident;
   logic               dlab, wr_ier, ien_tx_rise, pending, thre_pend;

   uart_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr   (addr),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   assign dlab        = lcr_q[DLAB];
   assign tx_wr       = wr_hit[OFS_DATA] & ~dlab;
   assign tx_data     = wdata;
   assign rx_rd       = rd_hit[OFS_DATA] & ~dlab;
   assign wr_ier      = wr_hit[OFS_IEN] & ~dlab;
   assign ien_tx_rise = wr_ier & wdata[IEN_TX] & ~ier_q[IEN_TX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         ier_q <= '0;
         mcr_q <= '0;
         scr_q <= '0;
         dll_q <= '0;
         dlm_q <= '0;
      end else begin
         if (wr_hit[OFS_LINE])          lcr_q <= wdata;
         if (wr_ier)                    ier_q <= wdata[IEN_W-1:0];
         if (wr_hit[OFS_MODEM])         mcr_q <= wdata[MCR_W-1:0];
         if (wr_hit[OFS_SCR])           scr_q <= wdata;
         if (wr_hit[OFS_DATA] && dlab)  dll_q <= wdata;
         if (wr_hit[OFS_IEN]  && dlab)  dlm_q <= wdata;
      end
   end

   if (FIFO_PRESENT) begin : g_fifo
      logic       fifo_q;
      logic [1:0] trig_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fifo_q <= 1'b0;
            trig_q <= '0;
         end else if (wr_hit[OFS_IDENT]) begin
            fifo_q <= wdata[0];
            trig_q <= wdata[DATA_W-1:DATA_W-2];
         end
      end
      assign fifo_en     = fifo_q;
      assign rx_trig     = trig_q;
      assign rx_fifo_clr = wr_hit[OFS_IDENT] & wdata[1];
      assign tx_fifo_clr = wr_hit[OFS_IDENT] & wdata[2];
   end else begin : g_no_fifo
      assign fifo_en     = 1'b0;
      assign rx_trig     = '0;
      assign rx_fifo_clr = 1'b0;
      assign tx_fifo_clr = 1'b0;
   end

   uart_regbank_flags #(.N(ERR_N)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (line_err),
      .clr    (rd_hit[OFS_LSTAT]),
      .flag_q (err_q)
   );

   uart_regbank_modem #(.LINES(MODEM_N)) u_modem (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (modem_in),
      .clr      (rd_hit[OFS_MSTAT]),
      .level_q  (msr_lvl),
      .delta_q  (msr_dlt)
   );

   uart_regbank_irq #(.IEN_W(IEN_W), .DATA_W(DATA_W)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien         (ier_q),
      .line_act    (|err_q),
      .rx_ready    (rx_ready),
      .rx_timeout  (rx_timeout),
      .modem_act   (|msr_dlt),
      .thr_empty   (thr_empty),
      .ien_tx_rise (ien_tx_rise),
      .tx_wr       (tx_wr),
      .ident_rd    (rd_hit[OFS_IDENT]),
      .fifo_on     (fifo_en),
      .ident       (ident),
      .pending     (pending),
      .thre_pend   (thre_pend)
   );

   always_comb begin
      case (addr)
         OFS_DATA:  rdata = dlab ? dll_q : rx_byte;
         OFS_IEN:   rdata = dlab ? dlm_q : {{(DATA_W-IEN_W){1'b0}}, ier_q};
         OFS_IDENT: rdata = ident;
         OFS_LINE:  rdata = lcr_q;
         OFS_MODEM: rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
         OFS_LSTAT: rdata = {1'b0, tx_idle, thr_empty, err_q, rx_ready};
         OFS_MSTAT: rdata = {msr_lvl, msr_dlt};
         default:   rdata = scr_q;
      endcase
   end

   assign divisor   = {dlm_q, dll_q};
   assign word_len  = lcr_q[1:0];
   assign stop_bits = lcr_q[2];
   assign par_en    = lcr_q[3];
   assign par_even  = lcr_q[4];
   assign par_stick = lcr_q[5];
   assign brk       = lcr_q[6];
   assign dtr       = mcr_q[0];
   assign rts       = mcr_q[1];
   assign out1      = mcr_q[2];
   assign out2      = mcr_q[3];
   assign irq       = out2 & pending;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int DATA_W  = 8,
   parameter int ERR_N   = 4,
   parameter int MODEM_N = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         addr,
   input logic               rd_en,
   input logic               wr_en,
   input logic [DATA_W-1:0]  rdata,
   input logic               irq,
   input logic               tx_wr,
   input logic               rx_rd,
   input logic               thr_empty,
   input logic [ERR_N-1:0]   line_err,
   input logic [MODEM_N-1:0] modem_in,
   input logic [DATA_W-1:0]  lcr_q,
   input logic [ERR_N-1:0]   err_q,
   input logic [MODEM_N-1:0] msr_lvl,
   input logic [MODEM_N-1:0] msr_dlt,
   input logic               thre_pend
);
   assert_tx_no_dlab_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |-> (wr_en && !lcr_q[DATA_W-1]));

   assert_rx_no_dlab_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |-> (rd_en && !lcr_q[DATA_W-1]));

   assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd2 && rdata[0]) |-> !irq);

   assert_line_id_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd2 && rdata[3:0] == 4'h6) |-> (|err_q));

   assert_lstat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd5 && line_err == '0) |=> (err_q == '0));

   assert_thre_drop_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && $stable(thr_empty)) |=> !thre_pend);

   assert_mstat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 3'd6 && modem_in == msr_lvl) |=> (msr_dlt == '0));
endmodule

bind uart_regbank uart_regbank_chk #(
   .DATA_W  (DATA_W),
   .ERR_N   (ERR_N),
   .MODEM_N (MODEM_N)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .rdata     (rdata),
   .irq       (irq),
   .tx_wr     (tx_wr),
   .rx_rd     (rx_rd),
   .thr_empty (thr_empty),
   .line_err  (line_err),
   .modem_in  (modem_in),
   .lcr_q     (lcr_q),
   .err_q     (err_q),
   .msr_lvl   (msr_lvl),
   .msr_dlt   (msr_dlt),
   .thre_pend (thre_pend)
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  rx_byte = 8'h5A;
   logic        rx_ready = 1'b0, rx_timeout = 1'b0;
   logic [3:0]  line_err = '0;
   logic        thr_empty = 1'b1, tx_idle = 1'b1;
   logic [3:0]  modem_in = '0;
   logic        tx_wr, rx_rd, fifo_en, rx_fifo_clr, tx_fifo_clr;
   logic [7:0]  tx_data;
   logic [1:0]  rx_trig, word_len;
   logic [15:0] divisor;
   logic        stop_bits, par_en, par_even, par_stick, brk;
   logic        dtr, rts, out1, out2, irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   uart_regbank i_uart_regbank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_ready(rx_ready),
      .rx_timeout(rx_timeout), .line_err(line_err), .thr_empty(thr_empty),
      .tx_idle(tx_idle), .modem_in(modem_in), .tx_wr(tx_wr), .tx_data(tx_data),
      .rx_rd(rx_rd), .fifo_en(fifo_en), .rx_fifo_clr(rx_fifo_clr),
      .tx_fifo_clr(tx_fifo_clr), .rx_trig(rx_trig), .divisor(divisor),
      .word_len(word_len), .stop_bits(stop_bits), .par_en(par_en),
      .par_even(par_even), .par_stick(par_stick), .brk(brk), .dtr(dtr),
      .rts(rts), .out1(out1), .out2(out2), .irq(irq)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v;
      rd(a, v);
      check({8'h0, v}, {8'h0, exp}, tag);
   endtask

   task automatic arm_tx_empty();
      @(negedge clk); thr_empty = 1'b0;
      @(negedge clk); thr_empty = 1'b1;
      @(negedge clk);
   endtask

   // vector: {is_read, offset, requirement number, data (write value or expected read)}
   localparam int NV = 34;
   localparam logic [15:0] VEC [NV] = '{
      {1'b1, 3'd2, 4'd1,  8'h01},  // R1 ident at reset
      {1'b1, 3'd1, 4'd1,  8'h00},  // R1
      {1'b1, 3'd3, 4'd1,  8'h00},  // R1
      {1'b1, 3'd4, 4'd1,  8'h00},  // R1
      {1'b1, 3'd7, 4'd1,  8'h00},  // R1
      {1'b1, 3'd5, 4'd6,  8'h60},  // R6 idle line status
      {1'b1, 3'd6, 4'd8,  8'h00},  // R8
      {1'b0, 3'd3, 4'd2,  8'h83},  // R2 divisor access on
      {1'b1, 3'd3, 4'd2,  8'h83},
      {1'b0, 3'd0, 4'd2,  8'h34},
      {1'b0, 3'd1, 4'd2,  8'h12},
      {1'b1, 3'd0, 4'd2,  8'h34},  // R2 divisor low
      {1'b1, 3'd1, 4'd2,  8'h12},  // R2 divisor high
      {1'b0, 3'd3, 4'd3,  8'h03},
      {1'b1, 3'd1, 4'd2,  8'h00},  // R2 enable reg untouched by divisor writes
      {1'b0, 3'd1, 4'd2,  8'hFF},
      {1'b1, 3'd1, 4'd2,  8'h0F},  // R2 upper bits read 0
      {1'b1, 3'd2, 4'd7,  8'h02},  // R7 armed by enable rise
      {1'b1, 3'd2, 4'd7,  8'h01},  // R7 cleared by ident read
      {1'b0, 3'd1, 4'd7,  8'h00},
      {1'b0, 3'd7, 4'd10, 8'hA5},
      {1'b0, 3'd5, 4'd10, 8'hFF},
      {1'b0, 3'd6, 4'd10, 8'hFF},
      {1'b1, 3'd7, 4'd10, 8'hA5},  // R10 scratch
      {1'b1, 3'd5, 4'd10, 8'h60},  // R10 write ignored
      {1'b1, 3'd6, 4'd10, 8'h00},  // R10 write ignored
      {1'b0, 3'd2, 4'd9,  8'hC1},
      {1'b1, 3'd2, 4'd9,  8'hC1},  // R9 fifo bits
      {1'b0, 3'd2, 4'd9,  8'h00},
      {1'b1, 3'd2, 4'd9,  8'h01},  // R9
      {1'b0, 3'd4, 4'd4,  8'h0B},
      {1'b1, 3'd4, 4'd4,  8'h0B},  // R4
      {1'b0, 3'd4, 4'd4,  8'h00},
      {1'b1, 3'd0, 4'd2,  8'h5A}   // R2 receive byte
   };

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(divisor, 16'h0000, "R1 divisor");
      check({15'h0, irq}, 16'h0, "R1 irq");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][15]) rd_chk(VEC[i][14:12], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][11:8], i));
         else            wr(VEC[i][14:12], VEC[i][7:0]);
      end

      check(divisor, 16'h1234, "R2 divisor out");

      wr(3, 8'h6D);
      check({8'h0, word_len, stop_bits, par_en, par_even, par_stick, brk},
            {8'h0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, "R3 fields");
      wr(3, 8'h03);

      @(negedge clk); addr = 0; wdata = 8'h77; wr_en = 1'b1;
      #1 check({7'h0, tx_wr, tx_data}, {7'h0, 1'b1, 8'h77}, "R2 tx strobe");
      @(negedge clk); wr_en = 1'b0;
      #1 check({15'h0, tx_wr}, 16'h0, "R2 tx strobe one cycle");
      wr(3, 8'h80);
      @(negedge clk); addr = 0; wdata = 8'h77; wr_en = 1'b1;
      #1 check({15'h0, tx_wr}, 16'h0, "R2 no tx strobe with divisor access");
      @(negedge clk); wr_en = 1'b0;
      check(divisor, 16'h1277, "R2 divisor low rewritten");
      @(negedge clk); addr = 0; rd_en = 1'b1;
      #1 check({15'h0, rx_rd}, 16'h0, "R2 no rx strobe with divisor access");
      @(negedge clk); rd_en = 1'b0;
      wr(3, 8'h03);
      @(negedge clk); addr = 0; rd_en = 1'b1;
      #1 check({15'h0, rx_rd}, 16'h1, "R2 rx strobe");
      @(negedge clk); rd_en = 1'b0;

      wr(4, 8'h0F);
      check({12'h0, out2, out1, rts, dtr}, 16'hF, "R4 modem outputs");

      // line status source
      wr(1, 8'h04);
      @(negedge clk); line_err = 4'b0101;
      @(negedge clk); line_err = 4'b0000;
      rd_chk(2, 8'h06, "R5 line status code");
      check({15'h0, irq}, 16'h1, "R4 irq with out2");
      wr(4, 8'h07);
      check({15'h0, irq}, 16'h0, "R4 irq gated by out2");
      wr(4, 8'h0F);
      rd_chk(5, 8'h6A, "R6 overrun and framing latched");
      rd_chk(2, 8'h01, "R6 line interrupt cleared");
      rd_chk(5, 8'h60, "R6 errors cleared");

      // all sources at once, removed in priority order
      wr(1, 8'h0F);
      arm_tx_empty();
      rx_ready = 1'b1; rx_timeout = 1'b1; line_err = 4'b1000; modem_in = 4'b1001;
      @(negedge clk); line_err = 4'b0000;
      rd_chk(2, 8'h06, "R5 line first");
      rd_chk(5, 8'h71, "R6 break with data ready");
      rd_chk(2, 8'h04, "R5 received data next");
      rx_ready = 1'b0;
      rd_chk(2, 8'h0C, "R5 timeout next");
      rx_timeout = 1'b0;
      rd_chk(2, 8'h02, "R7 tx empty survived other ident reads");
      rd_chk(2, 8'h00, "R5 modem last");
      rd_chk(6, 8'h99, "R8 levels and deltas");
      rd_chk(2, 8'h01, "R8 modem interrupt cleared");
      rd_chk(6, 8'h90, "R8 deltas cleared");

      // transmit write clears the tx empty source
      wr(1, 8'h02);
      arm_tx_empty();
      check({15'h0, irq}, 16'h1, "R7 armed by rising empty");
      wr(0, 8'h11);
      check({15'h0, irq}, 16'h0, "R7 cleared by transmit write");
      rd_chk(2, 8'h01, "R7 ident after write");

      // FIFO control strobes
      @(negedge clk); addr = 2; wdata = 8'hC7; wr_en = 1'b1;
      #1 check({14'h0, rx_fifo_clr, tx_fifo_clr}, 16'h3, "R9 clear pulses");
      @(negedge clk); wr_en = 1'b0;
      #1 check({13'h0, rx_fifo_clr, tx_fifo_clr, fifo_en}, 16'h1, "R9 pulses end, fifo on");
      check({14'h0, rx_trig}, 16'h3, "R9 trigger level");
      rd_chk(2, 8'hC1, "R9 ident fifo bits");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule